// File: doc/BRIEF.md
# Multi-Converter Serial ADC Sequencer

This block runs a small group of serial-output analog-to-digital converters with no processor in the loop. A free-running frame timer counts system clocks. On every second frame it drives one active-low conversion strobe, shared by every converter, so that all channels sample at the same instant. The strobe comes from hardware timing and not from software, so its jitter stays low enough for AC measurements.

After the strobe, the block watches each converter's busy line. A channel is read only after its busy line has gone from low to high. The channels are read one at a time in ascending order, each under its own active-low chip select, with a gated serial clock that toggles only during a transfer. Each 16-bit result is shifted in most significant bit first. It is presented for one clock on a valid/data/channel output.

Frame length, strobe width and serial clock half-period are static configuration inputs. A conversion tick that arrives while a previous round is still in progress is dropped, and a sticky overrun flag records the event.

Top module: `multi_adc_seq`

## Requirements
- R1: With a frame length F (0 is taken as 1), a conversion tick occurs every 2·F system clocks. When no tick is dropped, consecutive falling edges of `adc_conv_n` are exactly 2·F clocks apart. When ticks are dropped, the spacing is a nonzero multiple of 2·F.
- R2: `adc_conv_n` is one line shared by all converters. It is held low for exactly `cfg_strobe_len` clocks (0 is taken as 1), and no chip select is low while it is low.
- R3: At most one bit of `adc_cs_n` is low at any time.
- R4: The chip select of channel i falls only after `adc_busy[i]` has risen from low to high since the latest strobe began.
- R5: In each round, channels 0, 1, … NUM_CH-1 are selected once each in ascending order, and every channel's word of that conversion is delivered.
- R6: Between the release of one chip select and the fall of the next, all chip selects stay high for at least 2·H clocks, where H is the serial half-period (0 is taken as 1). Chip selects do not change while `adc_sclk` is high.
- R7: `adc_sclk` is low whenever no chip select is low. Inside a selection its first rise comes H clocks after the chip select falls, and every high and low phase after that lasts H clocks. Each selection has exactly 16 rising edges.
- R8: `adc_sdata` is sampled at each rising edge of `adc_sclk`. The first sampled bit becomes bit 15 of `res_data` and the last becomes bit 0.
- R9: `res_valid` is high for exactly one clock, in the cycle right after the 16th rising edge of `adc_sclk`. `res_chan` gives the binary index of the channel whose word is on `res_data`.
- R10: A conversion tick that arrives while the sequencer is not idle produces no strobe and sets `overrun`. Once set, `overrun` stays high until reset.
- R11: While `rst` is high: `adc_conv_n` is 1, every `adc_cs_n` bit is 1, and `adc_sclk`, `res_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_len | input | FRAME_W | Frame length in system clocks |
| cfg_strobe_len | input | STROBE_W | Conversion strobe width in system clocks |
| cfg_sclk_half | input | DIV_W | Serial clock half-period in system clocks |
| adc_busy | input | NUM_CH | Busy line of each converter; a rise marks a finished conversion |
| adc_sdata | input | 1 | Shared serial data from the selected converter |
| adc_conv_n | output | 1 | Shared active-low conversion strobe |
| adc_cs_n | output | NUM_CH | Active-low chip select of each converter |
| adc_sclk | output | 1 | Gated serial clock, idle low |
| res_valid | output | 1 | One-clock strobe for a finished word |
| res_data | output | 16 | Received word, MSB first on the wire |
| res_chan | output | CH_W | Channel index of the word |
| overrun | output | 1 | Sticky flag for a dropped conversion tick |

## Verification
The bench's converter model returns all-ones, all-zeros, single-end-bit and alternating words, then words computed per conversion. Any stuck, swapped or shifted bit therefore shows up as a wrong word on a given channel. The busy times differ per channel, and channel 0 is the slowest. This separates a design that waits on each busy rise from one that runs on fixed timing or reads whichever channel finishes first. Three configurations vary the serial divider, the strobe width (including a zero strobe length that must act as one) and the frame length. The shortest frame forces ticks to arrive during readout, which shows whether they are dropped with the sticky flag raised while the words still arrive intact.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int unsigned SAMPLE_W = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STROBE,
        SQ_WAIT,
        SQ_XFER,
        SQ_GAP
    } seq_state_e;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] bits;
    } sample_t;

endpackage

// File: rtl/adcseq_frame_timer.sv
module adcseq_frame_timer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned RATIO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic             conv_tick
);
    localparam int unsigned PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;
    logic [PH_W-1:0]  phase;
    logic             frame_tick;

    // a zero period behaves as one clock per frame
    assign cnt_last   = (period == '0) ? '0 : period - 1'b1;
    assign frame_tick = (cnt == cnt_last);
    assign conv_tick  = frame_tick && (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= '0;
        end else if (frame_tick) begin
            cnt   <= '0;
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcseq_busy_mon.sv
module adcseq_busy_mon #(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] busy_in,
    input  logic              clear,
    output logic [NUM_CH-1:0] done
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_lane
            logic [SYNC_STAGES-1:0] sync_q;
            logic                   prev_q;
            logic                   rise;

            assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    // converters idle with busy high
                    sync_q  <= '1;
                    prev_q  <= 1'b1;
                    done[g] <= 1'b0;
                end else begin
                    sync_q <= SYNC_STAGES'({sync_q, busy_in[g]});
                    prev_q <= sync_q[SYNC_STAGES-1];
                    if (clear) begin
                        done[g] <= 1'b0;
                    end else if (rise) begin
                        done[g] <= 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/adcseq_serial_rx.sv
module adcseq_serial_rx
    import adcseq_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half,
    input  logic             sdata,
    output logic             sclk,
    output sample_t          sample,
    output logic             fin
);
    localparam int unsigned BIT_W = $clog2(SAMPLE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SAMPLE_W - 1);

    logic                running;
    logic [DIV_W-1:0]    hc;
    logic [DIV_W-1:0]    hc_last;
    logic [BIT_W-1:0]    bitc;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] shifted;

    assign hc_last = (half == '0) ? '0 : half - 1'b1;
    assign shifted = {shreg[SAMPLE_W-2:0], sdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            hc      <= '0;
            bitc    <= '0;
            shreg   <= '0;
            sclk    <= 1'b0;
            sample  <= '0;
            fin     <= 1'b0;
        end else begin
            sample.valid <= 1'b0;
            fin          <= 1'b0;
            if (start) begin
                running <= 1'b1;
                hc      <= '0;
                bitc    <= '0;
                sclk    <= 1'b0;
            end else if (running) begin
                if (hc == hc_last) begin
                    hc <= '0;
                    if (!sclk) begin
                        // rising edge: capture the bit on the line
                        sclk  <= 1'b1;
                        shreg <= shifted;
                        if (bitc == BIT_LAST) begin
                            sample.valid <= 1'b1;
                            sample.bits  <= shifted;
                        end
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == BIT_LAST) begin
                            running <= 1'b0;
                            fin     <= 1'b1;
                        end else begin
                            bitc <= bitc + 1'b1;
                        end
                    end
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/multi_adc_seq.sv
module multi_adc_seq
    import adcseq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned FRAME_W     = 16,
    parameter int unsigned STROBE_W    = 4,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FRAME_RATIO = 2,
    localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [FRAME_W-1:0]  cfg_frame_len,
    input  logic [STROBE_W-1:0] cfg_strobe_len,
    input  logic [DIV_W-1:0]    cfg_sclk_half,
    input  logic [NUM_CH-1:0]   adc_busy,
    input  logic                adc_sdata,
    output logic                adc_conv_n,
    output logic [NUM_CH-1:0]   adc_cs_n,
    output logic                adc_sclk,
    output logic                res_valid,
    output logic [SAMPLE_W-1:0] res_data,
    output logic [CH_W-1:0]     res_chan,
    output logic                overrun
);
    localparam int unsigned GAP_W = DIV_W + 1;
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

    seq_state_e          state;
    logic [CH_W-1:0]     ch;
    logic [STROBE_W-1:0] scnt;
    logic [STROBE_W-1:0] strobe_last;
    logic [GAP_W-1:0]    gcnt;
    logic [GAP_W-1:0]    gap_last;
    logic [DIV_W-1:0]    half_eff;
    logic                conv_tick;
    logic [NUM_CH-1:0]   done;
    logic                ch_ready;
    logic                rx_start;
    logic                rx_fin;
    sample_t             rx_sample;
    logic                cs_act;
    logic                conv_n_q;
    logic                ovr_q;

    adcseq_frame_timer #(
        .CNT_W (FRAME_W),
        .RATIO (FRAME_RATIO)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .period    (cfg_frame_len),
        .conv_tick (conv_tick)
    );

    adcseq_busy_mon #(
        .NUM_CH      (NUM_CH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_busy (
        .clk     (clk),
        .rst     (rst),
        .busy_in (adc_busy),
        .clear   (state == SQ_STROBE),
        .done    (done)
    );

    adcseq_serial_rx #(
        .DIV_W (DIV_W)
    ) u_rx (
        .clk    (clk),
        .rst    (rst),
        .start  (rx_start),
        .half   (cfg_sclk_half),
        .sdata  (adc_sdata),
        .sclk   (adc_sclk),
        .sample (rx_sample),
        .fin    (rx_fin)
    );

    assign strobe_last = (cfg_strobe_len == '0) ? '0 : cfg_strobe_len - 1'b1;
    assign half_eff    = (cfg_sclk_half == '0) ? DIV_W'(1) : cfg_sclk_half;
    assign gap_last    = {half_eff, 1'b0} - GAP_W'(1);

    always_comb begin
        ch_ready = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch == CH_W'(i)) begin
                ch_ready = done[i];
            end
        end
    end

    assign rx_start = (state == SQ_WAIT) && ch_ready;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_cs
            assign adc_cs_n[g] = ~(cs_act && (ch == CH_W'(g)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            ch       <= '0;
            scnt     <= '0;
            gcnt     <= '0;
            conv_n_q <= 1'b1;
            cs_act   <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (conv_tick && (state != SQ_IDLE)) begin
                ovr_q <= 1'b1;
            end
            case (state)
                SQ_IDLE: begin
                    if (conv_tick) begin
                        state    <= SQ_STROBE;
                        scnt     <= '0;
                        conv_n_q <= 1'b0;
                        ch       <= '0;
                    end
                end
                SQ_STROBE: begin
                    if (scnt == strobe_last) begin
                        conv_n_q <= 1'b1;
                        state    <= SQ_WAIT;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (ch_ready) begin
                        cs_act <= 1'b1;
                        state  <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (rx_fin) begin
                        cs_act <= 1'b0;
                        gcnt   <= '0;
                        state  <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gcnt == gap_last) begin
                        if (ch == CH_LAST) begin
                            ch    <= '0;
                            state <= SQ_IDLE;
                        end else begin
                            ch    <= ch + 1'b1;
                            state <= SQ_WAIT;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign adc_conv_n = conv_n_q;
    assign overrun    = ovr_q;
    assign res_valid  = rx_sample.valid;
    assign res_data   = rx_sample.bits;
    assign res_chan   = ch;
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_conv_n,
    input logic [NUM_CH-1:0] adc_cs_n,
    input logic              adc_sclk,
    input logic              res_valid,
    input logic              overrun
);
    p_single_select_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(~adc_cs_n) <= 1);

    p_no_select_in_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !adc_conv_n |-> (&adc_cs_n));

    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (&adc_cs_n) |-> !adc_sclk);

    p_cs_steady_sclk_high_r6: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> $stable(adc_cs_n));

    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind multi_adc_seq adcseq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adc_conv_n (adc_conv_n),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .res_valid  (res_valid),
    .overrun    (overrun)
);

// File: tb/multi_adc_seq_tb_top.sv
module multi_adc_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_frame_len = 16'd200;
    logic [3:0]  cfg_strobe_len = 4'd4;
    logic [7:0]  cfg_sclk_half = 8'd2;
    logic [2:0]  adc_busy = 3'b111;
    logic        adc_sdata = 1'b0;
    logic        adc_conv_n;
    logic [2:0]  adc_cs_n;
    logic        adc_sclk;
    logic        res_valid;
    logic [15:0] res_data;
    logic [1:0]  res_chan;
    logic        overrun;

    always #10 clk = ~clk;

    multi_adc_seq dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_frame_len  (cfg_frame_len),
        .cfg_strobe_len (cfg_strobe_len),
        .cfg_sclk_half  (cfg_sclk_half),
        .adc_busy       (adc_busy),
        .adc_sdata      (adc_sdata),
        .adc_conv_n     (adc_conv_n),
        .adc_cs_n       (adc_cs_n),
        .adc_sclk       (adc_sclk),
        .res_valid      (res_valid),
        .res_data       (res_data),
        .res_chan       (res_chan),
        .overrun        (overrun)
    );

    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // effective configuration seen by the model
    int  eff_f = 200, eff_l = 4, eff_h = 2;
    bit  allow_ovr = 0;
    int  ctime [3] = '{60, 25, 40};

    // behavioural model state
    int          busy_tmr [3];
    bit          risen [3];
    logic [15:0] cur_word [3];
    logic [15:0] exp_q [$];
    int          exp_ch_q [$];
    int          conv_idx, since_fall, low_cnt, gap_cnt, next_ch, run, rises, ptr;
    logic        prev_conv, prev_sclk;
    logic [2:0]  prev_cs;

    function automatic logic [15:0] pat(input int n, input int i);
        case (n)
            0: return (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : 16'h8001;
            1: return (i == 0) ? 16'hA5A5 : (i == 1) ? 16'h5A5A : 16'h0001;
            default: return 16'((n * 32'h3C1D + i * 32'h7E53) ^ 32'h9A6B);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            adc_busy   = 3'b111;
            adc_sdata  = 1'b0;
            conv_idx   = 0;
            since_fall = -1;
            low_cnt    = 0;
            gap_cnt    = 0;
            next_ch    = 0;
            run        = 0;
            rises      = 0;
            ptr        = 15;
            exp_q.delete();
            exp_ch_q.delete();
            for (int i = 0; i < 3; i++) begin
                busy_tmr[i] = 0;
                risen[i]    = 0;
                cur_word[i] = '0;
            end
            prev_conv = 1'b1;
            prev_cs   = 3'b111;
            prev_sclk = 1'b0;
        end else begin
            bit sclk_rose;
            sclk_rose = 0;
            // converter busy timers
            for (int i = 0; i < 3; i++) begin
                if (!adc_busy[i]) begin
                    busy_tmr[i]--;
                    if (busy_tmr[i] <= 0) begin
                        adc_busy[i] = 1'b1;
                        risen[i]    = 1;
                    end
                end
            end
            // shared strobe
            if (since_fall >= 0) since_fall++;
            if (prev_conv && !adc_conv_n) begin
                if (since_fall >= 0) begin
                    if (!allow_ovr)
                        check(since_fall == 2 * eff_f, "R1", "strobe spacing", since_fall, 2 * eff_f);
                    else
                        check(since_fall > 0 && (since_fall % (2 * eff_f)) == 0, "R1",
                              "strobe spacing multiple", since_fall, 2 * eff_f);
                end
                since_fall = 0;
                low_cnt    = 1;
                for (int i = 0; i < 3; i++) begin
                    adc_busy[i] = 1'b0;
                    busy_tmr[i] = ctime[i];
                    risen[i]    = 0;
                    cur_word[i] = pat(conv_idx, i);
                    exp_q.push_back(cur_word[i]);
                    exp_ch_q.push_back(i);
                end
                conv_idx++;
            end else if (!adc_conv_n) begin
                low_cnt++;
            end
            if (!prev_conv && adc_conv_n)
                check(low_cnt == eff_l, "R2", "strobe width", low_cnt, eff_l);

            check($countones(~adc_cs_n) <= 1, "R3", "chip selects low", int'(~adc_cs_n), 0);

            // chip select events and serial clock
            if (&adc_cs_n) begin
                check(!adc_sclk, "R7", "sclk idle while deselected", adc_sclk, 0);
            end
            for (int i = 0; i < 3; i++) begin
                if (prev_cs[i] && !adc_cs_n[i]) begin
                    check(risen[i], "R4", $sformatf("busy rise before select ch%0d", i), risen[i], 1);
                    check(i == next_ch, "R5", "channel order", i, next_ch);
                    if (next_ch > 0)
                        check(gap_cnt >= 2 * eff_h, "R6", "deselect gap", gap_cnt, 2 * eff_h);
                    check(!adc_sclk, "R7", "sclk low at select", adc_sclk, 0);
                    ptr   = 15;
                    run   = 1;
                    rises = 0;
                end else if (!prev_cs[i] && !adc_cs_n[i]) begin
                    if (adc_sclk != prev_sclk) begin
                        check(run == eff_h, "R7", "sclk phase length", run, eff_h);
                        run = 1;
                        if (adc_sclk) begin
                            rises++;
                            sclk_rose = 1;
                        end else begin
                            ptr--;
                        end
                    end else begin
                        run++;
                    end
                end else if (!prev_cs[i] && adc_cs_n[i]) begin
                    check(rises == 16, "R7", "rising edges per word", rises, 16);
                    next_ch = (i + 1) % 3;
                    gap_cnt = 1;
                end
            end
            if ((&adc_cs_n) && (&prev_cs)) gap_cnt++;

            // result port timing and content
            check(res_valid == (sclk_rose && rises == 16), "R9", "valid timing",
                  res_valid, (sclk_rose && rises == 16));
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected word", res_data, 0);
                end else begin
                    logic [15:0] ew;
                    int          ec;
                    ew = exp_q.pop_front();
                    ec = exp_ch_q.pop_front();
                    check(res_data == ew, "R8", $sformatf("word ch%0d", ec), res_data, ew);
                    check(res_chan == 2'(ec), "R9", "channel index", res_chan, ec);
                end
            end
            if (!allow_ovr)
                check(overrun == 1'b0, "R10", "no overrun with slow frames", overrun, 0);

            // converter serial output
            adc_sdata = 1'b0;
            for (int i = 0; i < 3; i++)
                if (!adc_cs_n[i] && ptr >= 0 && ptr <= 15) adc_sdata = cur_word[i][ptr];

            prev_conv = adc_conv_n;
            prev_cs   = adc_cs_n;
            prev_sclk = adc_sclk;
        end
    end

    task automatic run_phase(input int f, input int l, input int h, input bit ovr, input int ncyc);
        @(negedge clk);
        rst            = 1'b1;
        cfg_frame_len  = 16'(f);
        cfg_strobe_len = 4'(l);
        cfg_sclk_half  = 8'(h);
        eff_f          = (f == 0) ? 1 : f;
        eff_l          = (l == 0) ? 1 : l;
        eff_h          = (h == 0) ? 1 : h;
        allow_ovr      = ovr;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(adc_conv_n == 1'b1, "R11", "strobe in reset", adc_conv_n, 1);
        check(adc_cs_n == 3'b111, "R11", "chip selects in reset", adc_cs_n, 7);
        check(adc_sclk == 1'b0, "R11", "sclk in reset", adc_sclk, 0);
        check(res_valid == 1'b0, "R11", "valid in reset", res_valid, 0);
        check(overrun == 1'b0, "R11", "overrun in reset", overrun, 0);
        rst = 1'b0;
        repeat (ncyc) @(posedge clk);
        begin
            int w;
            w = 0;
            while (exp_q.size() != 0 && w < 2000) begin
                @(posedge clk);
                w++;
            end
            check(exp_q.size() == 0, "R5", "all channel words delivered", exp_q.size(), 0);
        end
        if (ovr)
            check(overrun == 1'b1, "R10", "overrun after dropped ticks", overrun, 1);
    endtask

    initial begin
        run_phase(200, 4, 2, 0, 3000);
        run_phase(150, 0, 1, 0, 2400);
        run_phase(40, 7, 3, 1, 3000);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule